// File: doc/BRIEF.md
# Converter Trigger Latching Handler

This block sits in front of an analog-to-digital converter's sequencing logic. Four multiplexed conversion slots take hardware triggers that arrive with no fixed timing relation to the converter clock. The block brings each trigger into the converter clock domain and records it as pending. It then hands the pending triggers to the converter one at a time, and it waits for the converter's completion pulse before it issues the next one. When several slots are pending, the lowest-numbered slot goes first. Triggers for the direct slots (slot 4 and above) do not pass through the handler. They are forwarded to the converter unchanged. A monitor on the bus clock flags direct triggers that come too close together.

The host side runs on its own clock. It sees the following status bits:
- a pending bit per slot;
- an idle flag, high when no slot is pending;
- a sticky error bit per slot, set when a trigger arrives for a slot that is already pending (that extra trigger is dropped);
- a sticky spacing-error bit for the direct path.

Error bits are cleared by writing 1 to their position. The host can also issue a flush command, which discards every pending trigger. A trigger that has already been taken for launch, but is still in its setup window, is cancelled by a flush: no conversion starts for it and no completion follows.

All interfaces are plain control and status pins: single-cycle pulses and levels. None of them carries a data stream, so there is no valid/ready back-pressure anywhere. The converter must accept a launch pulse in the cycle it appears. The host must treat the flush and clear inputs as single host-clock pulses.

Top module: `adc_trig_latch_top`

## Requirements
- R1: `dir_trig_out` equals `dir_trig_in` at all times, with no register in the path.
- R2: A rising edge on `trig_in[i]`, held high for at least two converter-clock cycles, sets pending bit i. `stat_latched[i]` reads 1 within 3 converter cycles plus 3 host cycles. `stat_idle` is 1 exactly when `stat_latched` is all zeros.
- R3: After a launch, no further launch is issued until `conv_done` has pulsed. The completion clears the pending bit of the launched slot.
- R4: When several slots are pending, they are launched in ascending slot order, lowest index first.
- R5: A launch is a single converter-cycle pulse on `launch_valid`, with the slot index on `launch_slot` (slot i encoded as binary i). It is issued `LAUNCH_SETUP` converter cycles after the slot is taken.
- R6: A rising edge on `trig_in[i]` while pending bit i is already 1 sets `stat_err[i]`. That extra trigger produces no launch.
- R7: A host pulse on `clr_we` clears every status error bit whose `clr_bits` position is 1, and leaves bits written 0 unchanged. Bit positions: `clr_bits[3:0]` map to the slot errors 0 to 3, and `clr_bits[4]` maps to the direct-path spacing error.
- R8: A host pulse on `flush_req` clears all pending bits. A slot taken but not yet launched is cancelled, so no launch and no completion occur for it.
- R9: Two rising edges on `dir_trig_in` (any lanes) fewer than `MIN_GAP` host cycles apart set `stat_gap_err`. Edges exactly `MIN_GAP` cycles apart do not set it.
- R10: After reset, all pending and error bits are 0, `stat_idle` is 1, and no launch is issued.
- R11: A `conv_done` pulse while nothing is in flight is ignored: it does not change the status and it produces no launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cv | input | 1 | Converter clock |
| rst_cv_n | input | 1 | Converter-domain reset, active low, asynchronous |
| clk_hs | input | 1 | Host/bus clock |
| rst_hs_n | input | 1 | Host-domain reset, active low, asynchronous |
| trig_in | input | NUM_SLOTS | Asynchronous hardware triggers for the latched slots |
| conv_done | input | 1 | Conversion-complete pulse (converter domain) |
| launch_valid | output | 1 | Single-cycle launch pulse to the converter |
| launch_slot | output | SLOT_W | Slot index of the launch |
| flush_req | input | 1 | Host pulse: discard all pending triggers |
| clr_we | input | 1 | Host pulse: write-1-to-clear strobe for error bits |
| clr_bits | input | NUM_SLOTS+1 | Clear mask: slot errors in the low bits, spacing error on top |
| stat_latched | output | NUM_SLOTS | Pending bit per slot (host domain) |
| stat_err | output | NUM_SLOTS | Sticky per-slot overrun error (host domain) |
| stat_gap_err | output | 1 | Sticky direct-path spacing error |
| stat_idle | output | 1 | High when no slot is pending |
| dir_trig_in | input | NUM_DIRECT | Direct-path triggers |
| dir_trig_out | output | NUM_DIRECT | Direct-path triggers forwarded to the converter |

## Verification
The bench targets the following corner cases:
- **Launch ordering.** One slot is held in flight while three others become pending together. An arbiter with the wrong priority, or one that ignores the completion handshake, shows up as a misordered or doubled launch log.
- **Overrun on an in-flight slot.** A repeated trigger arrives for the slot that is in flight. A design that accepts it would launch that slot twice; a design that misses the error would leave `stat_err` low.
- **Write-1-to-clear.** Both a write of 0 and a write of 1 are made to an error position. A design that clears on any write would lose the sticky error on the write of 0.
- **Flush during the setup window.** The flush lands while a taken slot is in its setup window. A design that cancels only untaken slots would still launch.
- **Spacing boundary.** Direct edges are placed exactly `MIN_GAP` cycles apart and then one cycle closer. An off-by-one comparison either flags the legal spacing or misses the violation.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // Launch sequencer states (converter domain)
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // nothing in flight, looking for a pending slot
    ST_ARM  = 2'd1,  // slot taken, setup window running, flush can cancel
    ST_WAIT = 2'd2   // launched, waiting for conversion complete
  } launch_st_e;
endpackage

// File: rtl/adc_trig_sync.sv
// Multi-stage synchronizer, each bit independent.
module adc_trig_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_trig_launch.sv
// Converter-domain pending bits, overrun detection and one-at-a-time launch.
module adc_trig_launch
  import adc_trig_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int SLOT_W       = 2,
  parameter int LAUNCH_SETUP = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] trig_rise,
  input  logic                 flush_p,
  input  logic                 conv_done,
  output logic [NUM_SLOTS-1:0] latched,
  output logic [NUM_SLOTS-1:0] err_tgl,
  output logic                 launch_valid,
  output logic [SLOT_W-1:0]    launch_slot
);
  localparam int CW = $clog2(LAUNCH_SETUP + 1);

  launch_st_e             st;
  logic [SLOT_W-1:0]      cur;
  logic [CW-1:0]          setup_cnt;
  logic [SLOT_W-1:0]      pick;
  logic [NUM_SLOTS-1:0]   lat_nxt;
  logic [NUM_SLOTS-1:0]   err_evt;

  // Lowest-index pending slot wins
  always_comb begin
    pick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (latched[i]) pick = SLOT_W'(i);
    end
  end

  // Pending bit update: flush has priority over capture and completion
  always_comb begin
    lat_nxt = latched;
    err_evt = '0;
    if (flush_p) begin
      lat_nxt = '0;
    end else begin
      if (st == ST_WAIT && conv_done) lat_nxt[cur] = 1'b0;
      lat_nxt = lat_nxt | (trig_rise & ~latched);
      err_evt = trig_rise & latched;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched      <= '0;
      err_tgl      <= '0;
      st           <= ST_IDLE;
      cur          <= '0;
      setup_cnt    <= '0;
      launch_valid <= 1'b0;
      launch_slot  <= '0;
    end else begin
      latched      <= lat_nxt;
      err_tgl      <= err_tgl ^ err_evt;
      launch_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if ((|latched) && !flush_p) begin
            cur       <= pick;
            setup_cnt <= '0;
            st        <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (flush_p) begin
            st <= ST_IDLE;
          end else if (setup_cnt == CW'(LAUNCH_SETUP - 1)) begin
            launch_valid <= 1'b1;
            launch_slot  <= cur;
            st           <= ST_WAIT;
          end else begin
            setup_cnt <= setup_cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (conv_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_trig_host.sv
// Host-domain status: sticky W1C slot errors, idle flag, flush toggle.
module adc_trig_host #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_req,
  input  logic                 clr_we,
  input  logic [NUM_SLOTS-1:0] clr_slot,
  input  logic [NUM_SLOTS-1:0] latched_s,
  input  logic [NUM_SLOTS-1:0] err_tgl_s,
  output logic                 flush_tgl,
  output logic [NUM_SLOTS-1:0] err_set,
  output logic [NUM_SLOTS-1:0] stat_err,
  output logic                 stat_idle
);
  logic [NUM_SLOTS-1:0] err_tgl_prev;
  logic [NUM_SLOTS-1:0] clr_mask;

  assign err_set  = err_tgl_s ^ err_tgl_prev;
  assign clr_mask = clr_we ? clr_slot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_tgl_prev <= '0;
      stat_err     <= '0;
      flush_tgl    <= 1'b0;
    end else begin
      err_tgl_prev <= err_tgl_s;
      stat_err     <= (stat_err & ~clr_mask) | err_set;
      if (flush_req) flush_tgl <= ~flush_tgl;
    end
  end

  assign stat_idle = ~|latched_s;
endmodule

// File: rtl/adc_trig_gap_mon.sv
// Direct-path trigger spacing monitor on the bus clock.
module adc_trig_gap_mon #(
  parameter int NUM_DIRECT = 4,
  parameter int MIN_GAP    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIRECT-1:0] dir_in,
  input  logic                  clr_gap,
  output logic                  gap_err
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [NUM_DIRECT-1:0] prev;
  logic [GW-1:0]         since;
  logic                  edge_any;
  logic                  too_close;

  assign edge_any  = |(dir_in & ~prev);
  assign too_close = edge_any && (since < GW'(MIN_GAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      since   <= GW'(MIN_GAP);
      gap_err <= 1'b0;
    end else begin
      prev <= dir_in;
      if (edge_any)                    since <= GW'(1);
      else if (since != GW'(MIN_GAP))  since <= since + 1'b1;
      gap_err <= (gap_err & ~clr_gap) | too_close;
    end
  end
endmodule

// File: rtl/adc_trig_latch_top.sv
module adc_trig_latch_top #(
  parameter int NUM_SLOTS    = 4,
  parameter int NUM_DIRECT   = 4,
  parameter int MIN_GAP      = 4,
  parameter int LAUNCH_SETUP = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk_cv,
  input  logic                  rst_cv_n,
  input  logic                  clk_hs,
  input  logic                  rst_hs_n,
  input  logic [NUM_SLOTS-1:0]  trig_in,
  input  logic                  conv_done,
  output logic                  launch_valid,
  output logic [SLOT_W-1:0]     launch_slot,
  input  logic                  flush_req,
  input  logic                  clr_we,
  input  logic [NUM_SLOTS:0]    clr_bits,
  output logic [NUM_SLOTS-1:0]  stat_latched,
  output logic [NUM_SLOTS-1:0]  stat_err,
  output logic                  stat_gap_err,
  output logic                  stat_idle,
  input  logic [NUM_DIRECT-1:0] dir_trig_in,
  output logic [NUM_DIRECT-1:0] dir_trig_out
);
  // Converter domain
  logic [NUM_SLOTS-1:0] trig_s, trig_prev, trig_rise;
  logic                 flush_s, flush_prev, flush_cv_p;
  logic [NUM_SLOTS-1:0] latched_cv, err_tgl_cv;
  // Host domain
  logic                 flush_tgl_h;
  logic [NUM_SLOTS-1:0] err_tgl_h, err_set_h;

  assign dir_trig_out = dir_trig_in;

  adc_trig_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk_cv), .rst_n(rst_cv_n), .d(trig_in), .q(trig_s));

  adc_trig_sync #(.W(1), .STAGES(SYNC_STAGES)) u_flush_sync (
    .clk(clk_cv), .rst_n(rst_cv_n), .d(flush_tgl_h), .q(flush_s));

  always_ff @(posedge clk_cv or negedge rst_cv_n) begin
    if (!rst_cv_n) begin
      trig_prev  <= '0;
      flush_prev <= 1'b0;
    end else begin
      trig_prev  <= trig_s;
      flush_prev <= flush_s;
    end
  end

  assign trig_rise  = trig_s & ~trig_prev;
  assign flush_cv_p = flush_s ^ flush_prev;

  adc_trig_launch #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .LAUNCH_SETUP(LAUNCH_SETUP)
  ) u_launch (
    .clk(clk_cv), .rst_n(rst_cv_n), .trig_rise(trig_rise), .flush_p(flush_cv_p),
    .conv_done(conv_done), .latched(latched_cv), .err_tgl(err_tgl_cv),
    .launch_valid(launch_valid), .launch_slot(launch_slot));

  adc_trig_sync #(.W(2*NUM_SLOTS), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(clk_hs), .rst_n(rst_hs_n), .d({err_tgl_cv, latched_cv}),
    .q({err_tgl_h, stat_latched}));

  adc_trig_host #(.NUM_SLOTS(NUM_SLOTS)) u_host (
    .clk(clk_hs), .rst_n(rst_hs_n), .flush_req(flush_req), .clr_we(clr_we),
    .clr_slot(clr_bits[NUM_SLOTS-1:0]), .latched_s(stat_latched),
    .err_tgl_s(err_tgl_h), .flush_tgl(flush_tgl_h), .err_set(err_set_h),
    .stat_err(stat_err), .stat_idle(stat_idle));

  adc_trig_gap_mon #(.NUM_DIRECT(NUM_DIRECT), .MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk_hs), .rst_n(rst_hs_n), .dir_in(dir_trig_in),
    .clr_gap(clr_we & clr_bits[NUM_SLOTS]), .gap_err(stat_gap_err));
endmodule

// File: rtl/adc_trig_latch_chk.sv
module adc_trig_latch_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input logic                 clk_cv,
  input logic                 rst_cv_n,
  input logic                 clk_hs,
  input logic                 rst_hs_n,
  input logic                 launch_valid,
  input logic [SLOT_W-1:0]    launch_slot,
  input logic                 conv_done,
  input logic [NUM_SLOTS-1:0] latched_cv,
  input logic                 flush_cv_p,
  input logic                 clr_we,
  input logic [NUM_SLOTS:0]   clr_bits,
  input logic [NUM_SLOTS-1:0] err_set_h,
  input logic [NUM_SLOTS-1:0] stat_err,
  input logic                 stat_gap_err
);
  logic busy_q;
  always_ff @(posedge clk_cv or negedge rst_cv_n) begin
    if (!rst_cv_n)         busy_q <= 1'b0;
    else if (launch_valid) busy_q <= 1'b1;
    else if (conv_done)    busy_q <= 1'b0;
  end

  p_one_in_flight_r3: assert property (@(posedge clk_cv) disable iff (!rst_cv_n)
    launch_valid |-> !busy_q);

  p_launch_pending_r3: assert property (@(posedge clk_cv) disable iff (!rst_cv_n)
    launch_valid |-> latched_cv[launch_slot]);

  p_launch_pulse_r5: assert property (@(posedge clk_cv) disable iff (!rst_cv_n)
    launch_valid |=> !launch_valid);

  p_flush_clears_r8: assert property (@(posedge clk_cv) disable iff (!rst_cv_n)
    flush_cv_p |=> (latched_cv == '0));

  p_gap_sticky_r9: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
    $fell(stat_gap_err) |-> $past(clr_we && clr_bits[NUM_SLOTS]));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_w1c
    p_w1c_clear_r7: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
      (clr_we && clr_bits[i] && !err_set_h[i]) |=> !stat_err[i]);
    p_w1c_hold_r7: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
      (stat_err[i] && !(clr_we && clr_bits[i])) |=> stat_err[i]);
  end
endmodule

bind adc_trig_latch_top adc_trig_latch_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk_cv(clk_cv), .rst_cv_n(rst_cv_n), .clk_hs(clk_hs), .rst_hs_n(rst_hs_n),
  .launch_valid(launch_valid), .launch_slot(launch_slot), .conv_done(conv_done),
  .latched_cv(latched_cv), .flush_cv_p(flush_cv_p), .clr_we(clr_we),
  .clr_bits(clr_bits), .err_set_h(err_set_h), .stat_err(stat_err),
  .stat_gap_err(stat_gap_err));

// File: tb/adc_trig_latch_top_tb.sv
`timescale 1ns/1ps
module adc_trig_latch_top_tb;
  localparam int NS = 4;
  localparam int ND = 4;

  logic clk_hs = 1'b0, clk_cv = 1'b0;
  logic rst_hs_n = 1'b0, rst_cv_n = 1'b0;
  logic [NS-1:0] trig_in = '0;
  logic conv_done;
  logic done_auto = 1'b0, done_man = 1'b0;
  logic launch_valid;
  logic [1:0] launch_slot;
  logic flush_req = 1'b0, clr_we = 1'b0;
  logic [NS:0] clr_bits = '0;
  logic [NS-1:0] stat_latched, stat_err;
  logic stat_gap_err, stat_idle;
  logic [ND-1:0] dir_trig_in = '0, dir_trig_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk_hs = ~clk_hs;   // 100 MHz host/bus clock
  always #7 clk_cv = ~clk_cv;   // converter clock

  assign conv_done = done_auto | done_man;

  adc_trig_latch_top u_dut (
    .clk_cv(clk_cv), .rst_cv_n(rst_cv_n), .clk_hs(clk_hs), .rst_hs_n(rst_hs_n),
    .trig_in(trig_in), .conv_done(conv_done), .launch_valid(launch_valid),
    .launch_slot(launch_slot), .flush_req(flush_req), .clr_we(clr_we),
    .clr_bits(clr_bits), .stat_latched(stat_latched), .stat_err(stat_err),
    .stat_gap_err(stat_gap_err), .stat_idle(stat_idle),
    .dir_trig_in(dir_trig_in), .dir_trig_out(dir_trig_out));

  // Converter model: logs launches, answers with a completion pulse
  logic [1:0] log_slot [64];
  int nlog = 0, flight_err = 0, pulse_err = 0, dcnt = 0;
  bit busy = 0, auto_mode = 1, lv_prev = 0;

  always @(posedge clk_cv) begin
    done_auto <= 1'b0;
    lv_prev   <= launch_valid;
    if (launch_valid && lv_prev) pulse_err++;
    if (launch_valid) begin
      if (busy) flight_err++;
      if (nlog < 64) log_slot[nlog] = launch_slot;
      nlog++;
      busy = 1;
      dcnt = 0;
    end else if (busy) begin
      if (done_man) busy = 0;
      else if (auto_mode) begin
        dcnt++;
        if (dcnt == 5) begin done_auto <= 1'b1; busy = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_hs(input int n);
    repeat (n) @(negedge clk_hs);
  endtask

  task automatic pulse_trig(input logic [NS-1:0] m);
    @(negedge clk_hs); trig_in = trig_in | m;
    wait_hs(4);        trig_in = trig_in & ~m;
  endtask

  task automatic give_done();
    @(negedge clk_cv); done_man = 1'b1;
    @(negedge clk_cv); done_man = 1'b0;
  endtask

  task automatic host_clr(input logic [NS:0] v);
    @(negedge clk_hs); clr_we = 1'b1; clr_bits = v;
    @(negedge clk_hs); clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic pulse_dir(input int lane);
    @(negedge clk_hs); dir_trig_in[lane] = 1'b1;
    #1 chk(dir_trig_out == dir_trig_in, "R1 direct passthrough", dir_trig_out, dir_trig_in);
    @(negedge clk_hs); dir_trig_in[lane] = 1'b0;
  endtask

  task automatic t_reset();
    wait_hs(3);
    chk(stat_latched == 0, "R10 latched after reset", stat_latched, 0);
    chk(stat_err == 0, "R10 errors after reset", stat_err, 0);
    chk(stat_gap_err == 0, "R10 gap err after reset", stat_gap_err, 0);
    chk(stat_idle == 1, "R10 idle after reset", stat_idle, 1);
    chk(nlog == 0, "R10 no launch after reset", nlog, 0);
  endtask

  task automatic t_direct();
    pulse_dir(0);
    wait_hs(2);            // edges 4 cycles apart
    pulse_dir(1);
    wait_hs(3);
    chk(stat_gap_err == 0, "R9 spacing of MIN_GAP is legal", stat_gap_err, 0);
    pulse_dir(2);
    wait_hs(1);            // previous edge 3 cycles earlier
    pulse_dir(3);
    wait_hs(3);
    chk(stat_gap_err == 1, "R9 spacing below MIN_GAP flagged", stat_gap_err, 1);
    host_clr(5'b01111);
    wait_hs(2);
    chk(stat_gap_err == 1, "R7 writing 0 keeps gap error", stat_gap_err, 1);
    host_clr(5'b10000);
    wait_hs(2);
    chk(stat_gap_err == 0, "R7 writing 1 clears gap error", stat_gap_err, 0);
  endtask

  task automatic t_single();
    int n0 = nlog;
    auto_mode = 1;
    pulse_trig(4'b0010);
    wait_hs(4);
    chk(stat_latched == 4'b0010, "R2 pending bit visible", stat_latched, 4'b0010);
    chk(stat_idle == 0, "R2 not idle while pending", stat_idle, 0);
    wait_hs(60);
    chk(nlog == n0 + 1, "R5 one launch", nlog, n0 + 1);
    chk(log_slot[n0] == 2'd1, "R5 launch slot index", log_slot[n0], 1);
    chk(stat_latched == 0, "R3 completion clears pending", stat_latched, 0);
    chk(stat_idle == 1, "R2 idle after completion", stat_idle, 1);
  endtask

  task automatic t_priority();
    int n0 = nlog;
    auto_mode = 0;
    pulse_trig(4'b1000);
    wait_hs(40);
    chk(nlog == n0 + 1 && log_slot[n0] == 2'd3, "R4 first launch slot 3", log_slot[n0], 3);
    pulse_trig(4'b0111);
    wait_hs(30);
    chk(stat_latched == 4'b1111, "R2 all pending", stat_latched, 4'b1111);
    chk(nlog == n0 + 1, "R3 no launch before completion", nlog, n0 + 1);
    for (int k = 0; k < 3; k++) begin
      give_done();
      wait_hs(40);
      chk(nlog == n0 + 2 + k, "R3 one launch per completion", nlog, n0 + 2 + k);
      chk(log_slot[n0 + 1 + k] == 2'(k), "R4 ascending order", log_slot[n0 + 1 + k], k);
    end
    give_done();
    wait_hs(10);
    chk(stat_latched == 0, "R3 all drained", stat_latched, 0);
    auto_mode = 1;
  endtask

  task automatic t_error();
    int n0 = nlog;
    auto_mode = 0;
    pulse_trig(4'b0100);
    wait_hs(40);
    chk(nlog == n0 + 1, "R6 first trigger launched", nlog, n0 + 1);
    pulse_trig(4'b0100);
    wait_hs(10);
    chk(stat_err == 4'b0100, "R6 overrun sets error", stat_err, 4'b0100);
    host_clr(5'b00001);
    wait_hs(3);
    chk(stat_err == 4'b0100, "R7 writing 0 keeps slot error", stat_err, 4'b0100);
    give_done();
    wait_hs(40);
    chk(nlog == n0 + 1, "R6 extra trigger dropped", nlog, n0 + 1);
    chk(stat_latched == 0, "R6 no pending after drop", stat_latched, 0);
    host_clr(5'b00100);
    wait_hs(2);
    chk(stat_err == 0, "R7 writing 1 clears slot error", stat_err, 0);
    auto_mode = 1;
  endtask

  task automatic t_flush();
    int n0 = nlog;
    auto_mode = 1;
    pulse_trig(4'b0010);
    wait_hs(6);
    @(negedge clk_hs); flush_req = 1'b1;
    @(negedge clk_hs); flush_req = 1'b0;
    wait_hs(60);
    chk(nlog == n0, "R8 taken slot cancelled by flush", nlog, n0);
    chk(stat_latched == 0, "R8 flush clears pending", stat_latched, 0);
    chk(stat_idle == 1, "R8 idle after flush", stat_idle, 1);
    pulse_trig(4'b0001);
    wait_hs(60);
    chk(nlog == n0 + 1 && log_slot[n0] == 2'd0, "R8 launches resume after flush", nlog, n0 + 1);
  endtask

  task automatic t_spurious();
    int n0 = nlog;
    give_done();
    wait_hs(30);
    chk(nlog == n0, "R11 stray completion makes no launch", nlog, n0);
    chk(stat_latched == 0 && stat_idle == 1, "R11 stray completion leaves status", stat_latched, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_hs(4);
    rst_hs_n = 1'b1; rst_cv_n = 1'b1;
    t_reset();
    t_direct();
    t_single();
    t_priority();
    t_error();
    t_flush();
    t_spurious();
    chk(flight_err == 0, "R3 never two in flight", flight_err, 0);
    chk(pulse_err == 0, "R5 launch is one cycle", pulse_err, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule